// File: doc/BRIEF.md
# Illegal Instruction Exception Classifier

This block sits beside the decode stage of a small CPU with 16-bit opcodes. For every opcode the decoder presents, together with the decoder's class tag for it, the block decides whether the opcode is undefined on this particular build and in the present power state. Floating-point opcodes are undefined when the floating-point unit is absent or held in standby. Register-bank opcodes are undefined when the bank is absent. Opcodes the decoder already marks as undefined stay undefined.

An undefined opcode raises one of two exceptions. If it occupies the delay slot of a delayed branch, it raises a slot illegal exception. In every other position it raises a general illegal exception. The block also supplies the program counter value that the exception entry sequence must save. For a general exception this is the opcode's own address. For a slot exception it is the address of the owning branch, which is the opcode address minus one instruction width.

The verdict is registered and appears one clock after the opcode strobe. The exception entry sequence itself is handled elsewhere.

Top module: `illop_classifier`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released, exc_req_o is 2'b00, exc_type_o is 2'b00 and exc_pc_o is zero.
- R2: The class tag op_class_i uses this encoding: 2'b00 is defined base, 2'b01 is undefined base, 2'b10 is FPU-related and 2'b11 is bank-related. When an undefined opcode is accepted with in_slot_i low, the next cycle shows exc_type_o = 2'b01 and exc_req_o = 2'b01 (bit 0 is the general request).
- R3: When an undefined opcode is accepted with in_slot_i high, the next cycle shows exc_type_o = 2'b10 and exc_req_o = 2'b10 (bit 1 is the slot request). The general request stays low.
- R4: An opcode of class 2'b10 is undefined when fpu_present_i is low or fpu_standby_i is high. Otherwise it raises no exception.
- R5: An opcode of class 2'b11 is undefined when bank_present_i is low. Otherwise it raises no exception.
- R6: For a general illegal exception, exc_pc_o equals the op_addr_i of the offending opcode.
- R7: For a slot illegal exception, exc_pc_o equals op_addr_i minus INSN_BYTES (default 2), taken modulo 2^ADDR_W.
- R8: A cycle with op_valid_i low, or a valid opcode that is defined, gives exc_req_o = 2'b00, exc_type_o = 2'b00 and exc_pc_o = 0 in the next cycle.
- R9: fpu_standby_i is sampled with each opcode. A change between back-to-back opcodes affects only the opcodes that follow it.
- R10: exc_req_o never has more than one bit set, and the bit that is set always agrees with exc_type_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An opcode is presented this cycle |
| op_class_i | input | 2 | Decoder class tag (encoding in R2) |
| in_slot_i | input | 1 | The opcode occupies a delay slot |
| fpu_present_i | input | 1 | Strap: the floating-point unit is built in |
| fpu_standby_i | input | 1 | The floating-point unit is in module standby |
| bank_present_i | input | 1 | Strap: the register bank is built in |
| op_addr_i | input | ADDR_W | Start address of the opcode |
| exc_req_o | output | 2 | One-hot request: bit 0 general, bit 1 slot |
| exc_type_o | output | 2 | 00 none, 01 general illegal, 10 slot illegal |
| exc_pc_o | output | ADDR_W | PC value to save, zero when no request |

## Verification
Every result is due exactly one clock edge after the cycle in which its stimulus is driven. There is no other latency, and an idle cycle has a result due as well. The driver applies inputs on the falling edge and pushes one expected entry per cycle. The monitor pops and compares that entry shortly after the next rising edge, so each comparison lines up with the single register stage. Standby toggles between back-to-back opcodes and a slot opcode at address zero probe the per-opcode sampling and the wrap-around of the branch address.

// File: rtl/illop_pkg.sv
`timescale 1ns/1ps
package illop_pkg;

  typedef enum logic [1:0] {
    CLS_BASE_OK    = 2'b00,
    CLS_BASE_UNDEF = 2'b01,
    CLS_FPU        = 2'b10,
    CLS_BANK       = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'b00,
    EXC_GENERAL = 2'b01,
    EXC_SLOT    = 2'b10,
    EXC_RSVD    = 2'b11
  } exc_kind_e;

  localparam int unsigned NUM_REQ = 2;

endpackage

// File: rtl/illop_undef_check.sv
`timescale 1ns/1ps
module illop_undef_check
  import illop_pkg::*;
(
  input  op_class_e cls_i,
  input  logic      fpu_present_i,
  input  logic      fpu_standby_i,
  input  logic      bank_present_i,
  output logic      undef_o
);

  logic fpu_usable;
  assign fpu_usable = fpu_present_i & ~fpu_standby_i;

  always_comb begin
    unique case (cls_i)
      CLS_BASE_OK:    undef_o = 1'b0;
      CLS_BASE_UNDEF: undef_o = 1'b1;
      CLS_FPU:        undef_o = ~fpu_usable;
      CLS_BANK:       undef_o = ~bank_present_i;
      default:        undef_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/illop_route.sv
`timescale 1ns/1ps
module illop_route
  import illop_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 2
) (
  input  logic              valid_i,
  input  logic              undef_i,
  input  logic              in_slot_i,
  input  logic [ADDR_W-1:0] addr_i,
  output exc_kind_e         kind_o,
  output logic [ADDR_W-1:0] pc_o
);

  localparam logic [ADDR_W-1:0] SLOT_BACKOFF = ADDR_W'(INSN_BYTES);

  logic raise;
  assign raise = valid_i & undef_i;

  always_comb begin
    kind_o = EXC_NONE;
    pc_o   = '0;
    if (raise) begin
      if (in_slot_i) begin
        kind_o = EXC_SLOT;
        pc_o   = addr_i - SLOT_BACKOFF; // owning branch precedes the slot
      end else begin
        kind_o = EXC_GENERAL;
        pc_o   = addr_i;
      end
    end
  end

endmodule

// File: rtl/illop_out_reg.sv
`timescale 1ns/1ps
module illop_out_reg
  import illop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  exc_kind_e          kind_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic [NUM_REQ-1:0] req_o,
  output logic [1:0]         type_o,
  output logic [ADDR_W-1:0]  pc_o
);

  logic [NUM_REQ-1:0] req_d;

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
    assign req_d[k] = (kind_i == exc_kind_e'(2'(k + 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= '0;
      type_o <= EXC_NONE;
      pc_o   <= '0;
    end else begin
      req_o  <= req_d;
      type_o <= kind_i;
      pc_o   <= pc_i;
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o)) else $error("request not one-hot"); // R10
  AST_REQ_TYPE_GEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o[0] |-> type_o == EXC_GENERAL) else $error("general req/type mismatch"); // R10
  AST_REQ_TYPE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o[1] |-> type_o == EXC_SLOT) else $error("slot req/type mismatch"); // R10

endmodule

// File: rtl/illop_classifier.sv
`timescale 1ns/1ps
module illop_classifier
  import illop_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_class_i,
  input  logic              in_slot_i,
  input  logic              fpu_present_i,
  input  logic              fpu_standby_i,
  input  logic              bank_present_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  output logic [1:0]        exc_req_o,
  output logic [1:0]        exc_type_o,
  output logic [ADDR_W-1:0] exc_pc_o
);

  localparam logic [ADDR_W-1:0] SLOT_BACKOFF = ADDR_W'(INSN_BYTES);

  logic              undef;
  exc_kind_e         kind;
  logic [ADDR_W-1:0] pc_next;

  illop_undef_check i_undef_check (
    .cls_i          (op_class_e'(op_class_i)),
    .fpu_present_i  (fpu_present_i),
    .fpu_standby_i  (fpu_standby_i),
    .bank_present_i (bank_present_i),
    .undef_o        (undef)
  );

  illop_route #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES)
  ) i_route (
    .valid_i   (op_valid_i),
    .undef_i   (undef),
    .in_slot_i (in_slot_i),
    .addr_i    (op_addr_i),
    .kind_o    (kind),
    .pc_o      (pc_next)
  );

  illop_out_reg #(
    .ADDR_W (ADDR_W)
  ) i_out_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kind_i (kind),
    .pc_i   (pc_next),
    .req_o  (exc_req_o),
    .type_o (exc_type_o),
    .pc_o   (exc_pc_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> exc_req_o == 2'b00 && exc_pc_o == '0) else $error("request without opcode"); // R8
  AST_SLOT_NO_GENERAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && in_slot_i |=> !exc_req_o[0]) else $error("general raised in slot"); // R3
  AST_GEN_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !in_slot_i |=> !exc_req_o[0] || exc_pc_o == $past(op_addr_i)) else $error("general pc wrong"); // R6
  AST_SLOT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && in_slot_i |=> !exc_req_o[1] || exc_pc_o == $past(op_addr_i) - SLOT_BACKOFF) else $error("slot pc wrong"); // R7
  AST_FPU_USABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_class_i == 2'b10 && fpu_present_i && !fpu_standby_i |=> exc_req_o == 2'b00) else $error("usable fpu op flagged"); // R4
  AST_BANK_USABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_class_i == 2'b11 && bank_present_i |=> exc_req_o == 2'b00) else $error("usable bank op flagged"); // R5

endmodule

// File: tb/test_illop_classifier.sv
`timescale 1ns/1ps
module test_illop_classifier;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned WATCHDOG = 5000;

  typedef struct {
    logic [1:0]        req;
    logic [1:0]        kind;
    logic [ADDR_W-1:0] pc;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              op_valid = 1'b0;
  logic [1:0]        op_class = 2'b00;
  logic              in_slot = 1'b0;
  logic              fpu_present = 1'b1;
  logic              fpu_standby = 1'b0;
  logic              bank_present = 1'b1;
  logic [ADDR_W-1:0] op_addr = '0;
  logic [1:0]        exc_req;
  logic [1:0]        exc_type;
  logic [ADDR_W-1:0] exc_pc;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  illop_classifier #(.ADDR_W(ADDR_W), .INSN_BYTES(2)) i_illop_classifier (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .op_valid_i     (op_valid),
    .op_class_i     (op_class),
    .in_slot_i      (in_slot),
    .fpu_present_i  (fpu_present),
    .fpu_standby_i  (fpu_standby),
    .bank_present_i (bank_present),
    .op_addr_i      (op_addr),
    .exc_req_o      (exc_req),
    .exc_type_o     (exc_type),
    .exc_pc_o       (exc_pc)
  );

  task automatic drive(input logic v, input logic [1:0] cls, input logic slot,
                       input logic sby, input logic [ADDR_W-1:0] addr, input string tag);
    exp_t e;
    logic undef;
    @(negedge clk);
    op_valid = v; op_class = cls; in_slot = slot; fpu_standby = sby; op_addr = addr;
    undef = (cls == 2'b01) || (cls == 2'b10 && (!fpu_present || sby)) ||
            (cls == 2'b11 && !bank_present);
    e.tag = tag;
    if (v && undef && !slot) begin
      e.req = 2'b01; e.kind = 2'b01; e.pc = addr;
    end else if (v && undef && slot) begin
      e.req = 2'b10; e.kind = 2'b10; e.pc = addr - 32'd2;
    end else begin
      e.req = 2'b00; e.kind = 2'b00; e.pc = '0;
    end
    sb_q.push_back(e);
  endtask

  task automatic idle();
    drive(1'b0, 2'b01, 1'b0, fpu_standby, 32'h0000_0ABC, "R8 idle");
  endtask

  // monitor: result due one edge after the driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (exc_req !== e.req || exc_type !== e.kind || exc_pc !== e.pc ||
            $countones(exc_req) > 1) begin // R10
          n_fails++;
          $display("FAIL %s: req=%b type=%b pc=%h expected req=%b type=%b pc=%h",
                   e.tag, exc_req, exc_type, exc_pc, e.req, e.kind, e.pc);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    n_checks++;
    if (exc_req !== 2'b00 || exc_type !== 2'b00 || exc_pc !== '0) begin
      n_fails++;
      $display("FAIL R1 in reset: req=%b type=%b pc=%h expected 00 00 0", exc_req, exc_type, exc_pc);
    end
    rst_ni = 1'b1;
    @(posedge clk); #2;
    n_checks++;
    if (exc_req !== 2'b00 || exc_type !== 2'b00 || exc_pc !== '0) begin
      n_fails++;
      $display("FAIL R1 after release: req=%b type=%b pc=%h expected 00 00 0", exc_req, exc_type, exc_pc);
    end

    // all optional units present and awake
    drive(1'b1, 2'b00, 1'b0, 1'b0, 32'h0000_1000, "R8 defined base");
    drive(1'b1, 2'b01, 1'b0, 1'b0, 32'h0000_1000, "R2 R6 general undefined");
    drive(1'b1, 2'b01, 1'b1, 1'b0, 32'h0000_1002, "R3 R7 slot undefined");
    drive(1'b1, 2'b10, 1'b0, 1'b0, 32'h0000_2000, "R4 fpu usable");
    drive(1'b1, 2'b10, 1'b1, 1'b0, 32'h0000_2002, "R4 fpu usable in slot");
    drive(1'b1, 2'b11, 1'b0, 1'b0, 32'h0000_3000, "R5 bank present");
    drive(1'b0, 2'b01, 1'b1, 1'b0, 32'h0000_3002, "R8 valid low with undefined tag");
    drive(1'b1, 2'b01, 1'b0, 1'b0, 32'h0000_4000, "R2 back-to-back first");
    drive(1'b1, 2'b01, 1'b1, 1'b0, 32'h0000_4002, "R3 back-to-back slot");
    drive(1'b1, 2'b00, 1'b1, 1'b0, 32'h0000_4004, "R8 defined in slot");

    // standby toggled per opcode
    drive(1'b1, 2'b10, 1'b0, 1'b1, 32'h0000_5000, "R4 R9 fpu standby");
    drive(1'b1, 2'b10, 1'b0, 1'b0, 32'h0000_5002, "R9 fpu woken");
    drive(1'b1, 2'b10, 1'b1, 1'b1, 32'h0000_5006, "R9 R7 fpu standby in slot");
    drive(1'b1, 2'b10, 1'b0, 1'b0, 32'h0000_5008, "R9 fpu woken again");
    idle();

    // no floating-point unit
    fpu_present = 1'b0;
    idle();
    drive(1'b1, 2'b10, 1'b0, 1'b0, 32'h0000_6000, "R4 no fpu general");
    drive(1'b1, 2'b10, 1'b1, 1'b0, 32'h0000_6002, "R4 R3 no fpu slot");
    drive(1'b1, 2'b11, 1'b0, 1'b0, 32'h0000_6004, "R5 bank still present");
    fpu_present = 1'b1;
    idle();

    // no register bank
    bank_present = 1'b0;
    idle();
    drive(1'b1, 2'b11, 1'b0, 1'b0, 32'h0000_7000, "R5 R6 no bank general");
    drive(1'b1, 2'b11, 1'b1, 1'b0, 32'h0000_7002, "R5 R7 no bank slot");
    drive(1'b1, 2'b11, 1'b1, 1'b0, 32'h0000_0000, "R7 slot at address zero wraps");
    drive(1'b1, 2'b01, 1'b0, 1'b0, 32'hFFFF_FFFE, "R6 general at top address");
    drive(1'b1, 2'b10, 1'b0, 1'b0, 32'h0000_7004, "R4 fpu with bank absent");
    bank_present = 1'b1;
    idle();
    idle();

    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule